// File: doc/BRIEF.md
# Pad delay configuration register bank

This block is the software-visible register file of a pad delay controller. A host reaches it over a plain 32-bit request bus with one request per cycle. The bank holds a word-aligned array of delay slots. Each pad owns three consecutive slots, and each slot stores a coarse and a fine element count that drive the delay lines through flat parallel outputs. Three read-only calibration words show values that an external calibration engine supplies on input pins.

Slot writes are guarded in two ways. The whole slot region opens or closes only when a specific 16-bit key is written to the region key register. In addition, every slot word must carry a fixed signature, and a slot whose own lock bit is set accepts only a write that clears that bit. A write that fails any of these guards changes nothing. Reads take one cycle. A read past the top of the map returns zero and pulses an error flag.

Top module: `iodly_cfg_bank`

## Requirements
- R1: After reset the region is closed, the key register reads 0x0000AAAB, every slot reads with its lock bit (bit 10) set, and every coarse and fine output is zero.
- R2: A write to offset 0x2C whose low 16 bits are 0xAAAA opens the region. Low bits 0xAAAB close it. Any other value leaves the state unchanged, and bits 31:16 are ignored. A read of 0x2C returns 0x0000AAAA when open and 0x0000AAAB when closed.
- R3: While the region is closed, no slot write changes any slot.
- R4: A slot write whose bits 17:12 differ from 0x29 changes nothing.
- R5: While a slot's lock bit is set, a write to it with bit 10 set is ignored, and a write with bit 10 clear is accepted. An accepted write stores bit 10 as the new lock bit.
- R6: An accepted write stores bits 9:5 as the coarse count and bits 4:0 as the fine count. Slot k drives coarse_o[5k+4:5k] and fine_o[5k+4:5k], starting in the cycle after the write.
- R7: Offset 0x30+4k addresses slot k, which belongs to pad k/3, up to the last slot at 0xD1C (828 slots). Address bits 1:0 are ignored.
- R8: A slot read returns 0x29 in bits 17:12, zero in bit 11 and bits 31:18, the lock bit in bit 10, the coarse count in bits 9:5 and the fine count in bits 4:0.
- R9: Offset 0x14 reads the 16-bit reference period in bits 15:0. Offsets 0x18 and 0x1C read the coarse and fine calibration inputs with the delay count in bits 31:16 and the reference count in bits 15:0. Writes to these offsets have no effect.
- R10: A read above 0xD1C returns zero with rerr_o high for that one response. Unmapped offsets at or below 0xD1C read zero without an error.
- R11: Read data appears in the cycle after the request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset |
| wdata_i | input | 32 | Write data |
| refclk_period_i | input | 16 | Reference clock period from calibration |
| crs_ref_i | input | 16 | Coarse reference count |
| crs_dly_i | input | 16 | Coarse delay count |
| fin_ref_i | input | 16 | Fine reference count |
| fin_dly_i | input | 16 | Fine delay count |
| rdata_o | output | 32 | Read data, registered |
| rerr_o | output | 1 | Out-of-range read response |
| coarse_o | output | 4140 | Coarse counts, 5 bits per slot |
| fine_o | output | 4140 | Fine counts, 5 bits per slot |

## Verification
Slot writes are tried in every combination of region state, signature value and current and written lock bit. This separates a design that checks one gate from one that checks all of them. Writes to the first and last slots and just past the top of the map show whether the address decode is off by one, and reads of the key register before and after foreign key values show whether the key compare is exact. A seeded run of mixed slot writes and reads, checked each cycle against a behavioural model, catches field placement errors and writes that land in the wrong slot.

// File: rtl/iodly_pkg.sv
package iodly_pkg;
  localparam int ADDR_W   = 12;
  localparam int DATA_W   = 32;
  localparam int CNT_W    = 5;
  localparam int SIG_W    = 6;
  localparam int KEY_W    = 16;
  localparam int CAL_W    = 16;
  localparam int SIG_LSB  = 12;
  localparam int LOCK_BIT = 10;
  localparam int CRS_LSB  = 5;
  localparam int FIN_LSB  = 0;

  localparam logic [SIG_W-1:0] SIG_OK   = 6'h29;
  localparam logic [KEY_W-1:0] KEY_OPEN = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_SHUT = 16'hAAAB;

  localparam logic [ADDR_W-1:0] OFF_REFCLK = 12'h014;
  localparam logic [ADDR_W-1:0] OFF_CRSCAL = 12'h018;
  localparam logic [ADDR_W-1:0] OFF_FINCAL = 12'h01C;
  localparam logic [ADDR_W-1:0] OFF_KEY    = 12'h02C;

  typedef struct packed {
    logic             lock;
    logic [CNT_W-1:0] coarse;
    logic [CNT_W-1:0] fine;
  } slot_t;

  typedef struct packed {
    logic [SIG_W-1:0] sig;
    logic             lock;
    logic [CNT_W-1:0] coarse;
    logic [CNT_W-1:0] fine;
  } slot_wr_t;
endpackage

// File: rtl/iodly_key_ctrl.sv
module iodly_key_ctrl import iodly_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             open_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_o <= 1'b0;
    end else if (wr_i) begin
      if (key_i == KEY_OPEN)      open_o <= 1'b1;
      else if (key_i == KEY_SHUT) open_o <= 1'b0;
    end
  end
endmodule

// File: rtl/iodly_slot.sv
module iodly_slot import iodly_pkg::*; (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     we_i,
  input  logic     open_i,
  input  slot_wr_t wr_i,
  output slot_t    slot_o
);
  logic accept;

  // a set lock bit only yields to a write that clears it
  assign accept = we_i && open_i && (wr_i.sig == SIG_OK) &&
                  (!slot_o.lock || !wr_i.lock);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_o.lock   <= 1'b1;
      slot_o.coarse <= '0;
      slot_o.fine   <= '0;
    end else if (accept) begin
      slot_o.lock   <= wr_i.lock;
      slot_o.coarse <= wr_i.coarse;
      slot_o.fine   <= wr_i.fine;
    end
  end
endmodule

// File: rtl/iodly_rd_port.sv
module iodly_rd_port import iodly_pkg::*; #(
  parameter int NUM_SLOTS = 828,
  parameter int IDX_W     = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rd_i,
  input  logic [ADDR_W-3:0]       word_addr_i,
  input  logic                    slot_hit_i,
  input  logic                    oor_i,
  input  logic [IDX_W-1:0]        slot_idx_i,
  input  slot_t [NUM_SLOTS-1:0]   slots_i,
  input  logic                    open_i,
  input  logic [CAL_W-1:0]        refclk_period_i,
  input  logic [CAL_W-1:0]        crs_ref_i,
  input  logic [CAL_W-1:0]        crs_dly_i,
  input  logic [CAL_W-1:0]        fin_ref_i,
  input  logic [CAL_W-1:0]        fin_dly_i,
  output logic [DATA_W-1:0]       rdata_o,
  output logic                    rerr_o
);
  localparam int HI_PAD = DATA_W - SIG_LSB - SIG_W;
  localparam int CAL_PAD = DATA_W - CAL_W;

  logic [DATA_W-1:0] rd_word;
  slot_t             sel;

  assign sel = slots_i[slot_idx_i];

  always_comb begin
    rd_word = '0;
    if (slot_hit_i) begin
      rd_word = {{HI_PAD{1'b0}}, SIG_OK, 1'b0, sel.lock, sel.coarse, sel.fine};
    end else begin
      unique case (word_addr_i)
        OFF_KEY[ADDR_W-1:2]:    rd_word = {{(DATA_W-KEY_W){1'b0}}, open_i ? KEY_OPEN : KEY_SHUT};
        OFF_REFCLK[ADDR_W-1:2]: rd_word = {{CAL_PAD{1'b0}}, refclk_period_i};
        OFF_CRSCAL[ADDR_W-1:2]: rd_word = {crs_dly_i, crs_ref_i};
        OFF_FINCAL[ADDR_W-1:2]: rd_word = {fin_dly_i, fin_ref_i};
        default:                rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      rerr_o  <= 1'b0;
    end else begin
      rerr_o <= rd_i && oor_i;
      if (rd_i) rdata_o <= oor_i ? '0 : rd_word;
    end
  end
endmodule

// File: rtl/iodly_cfg_bank.sv
module iodly_cfg_bank import iodly_pkg::*; #(
  parameter int BASE_OFF     = 'h030,
  parameter int LAST_OFF     = 'hD1C,
  parameter int REGS_PER_PIN = 3,
  localparam int NUM_PINS    = (LAST_OFF - BASE_OFF) / (4 * REGS_PER_PIN) + 1,
  localparam int NUM_SLOTS   = NUM_PINS * REGS_PER_PIN
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [CAL_W-1:0]           refclk_period_i,
  input  logic [CAL_W-1:0]           crs_ref_i,
  input  logic [CAL_W-1:0]           crs_dly_i,
  input  logic [CAL_W-1:0]           fin_ref_i,
  input  logic [CAL_W-1:0]           fin_dly_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic                       rerr_o,
  output logic [NUM_SLOTS*CNT_W-1:0] coarse_o,
  output logic [NUM_SLOTS*CNT_W-1:0] fine_o
);
  localparam int WA_W      = ADDR_W - 2;
  localparam int IDX_W     = $clog2(NUM_SLOTS);
  localparam int BASE_WORD = BASE_OFF / 4;
  localparam int LAST_WORD = BASE_WORD + NUM_SLOTS - 1;
  localparam logic [WA_W-1:0] BASE_WA = WA_W'(BASE_WORD);
  localparam logic [WA_W-1:0] LAST_WA = WA_W'(LAST_WORD);

  logic [WA_W-1:0]        word_addr;
  logic [WA_W-1:0]        rel_addr;
  logic [IDX_W-1:0]       slot_idx;
  logic                   slot_hit;
  logic                   oor;
  logic                   wr, rd, key_wr;
  logic                   region_open;
  slot_wr_t               wr_fields;
  slot_t [NUM_SLOTS-1:0]  slots;

  assign word_addr = addr_i[ADDR_W-1:2];
  assign rel_addr  = word_addr - BASE_WA;
  assign slot_idx  = rel_addr[IDX_W-1:0];
  assign slot_hit  = (word_addr >= BASE_WA) && (word_addr <= LAST_WA);
  assign oor       = word_addr > LAST_WA;
  assign wr        = req_i && we_i;
  assign rd        = req_i && !we_i;
  assign key_wr    = wr && (word_addr == OFF_KEY[ADDR_W-1:2]);

  assign wr_fields.sig    = wdata_i[SIG_LSB +: SIG_W];
  assign wr_fields.lock   = wdata_i[LOCK_BIT];
  assign wr_fields.coarse = wdata_i[CRS_LSB +: CNT_W];
  assign wr_fields.fine   = wdata_i[FIN_LSB +: CNT_W];

  iodly_key_ctrl u_key (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (key_wr),
    .key_i  (wdata_i[KEY_W-1:0]),
    .open_o (region_open)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic slot_we;
    assign slot_we = wr && slot_hit && (slot_idx == IDX_W'(i));

    iodly_slot u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (slot_we),
      .open_i (region_open),
      .wr_i   (wr_fields),
      .slot_o (slots[i])
    );

    assign coarse_o[i*CNT_W +: CNT_W] = slots[i].coarse;
    assign fine_o[i*CNT_W +: CNT_W]   = slots[i].fine;
  end

  iodly_rd_port #(
    .NUM_SLOTS (NUM_SLOTS),
    .IDX_W     (IDX_W)
  ) u_rd (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .rd_i            (rd),
    .word_addr_i     (word_addr),
    .slot_hit_i      (slot_hit),
    .oor_i           (oor),
    .slot_idx_i      (slot_idx),
    .slots_i         (slots),
    .open_i          (region_open),
    .refclk_period_i (refclk_period_i),
    .crs_ref_i       (crs_ref_i),
    .crs_dly_i       (crs_dly_i),
    .fin_ref_i       (fin_ref_i),
    .fin_dly_i       (fin_dly_i),
    .rdata_o         (rdata_o),
    .rerr_o          (rerr_o)
  );
endmodule

// File: rtl/iodly_cfg_bank_chk.sv
module iodly_cfg_bank_chk import iodly_pkg::*; #(
  parameter int NUM_SLOTS = 828,
  parameter int BASE_OFF  = 'h030
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       req_i,
  input logic                       we_i,
  input logic [ADDR_W-1:0]          addr_i,
  input logic [DATA_W-1:0]          wdata_i,
  input logic [DATA_W-1:0]          rdata_o,
  input logic                       rerr_o,
  input logic [NUM_SLOTS*CNT_W-1:0] coarse_o,
  input logic [NUM_SLOTS*CNT_W-1:0] fine_o,
  input logic                       region_open
);
  localparam int BASE_W = BASE_OFF / 4;
  localparam int LAST_W = BASE_W + NUM_SLOTS - 1;

  logic [ADDR_W-3:0] wa;
  logic              slot_addr;
  assign wa        = addr_i[ADDR_W-1:2];
  assign slot_addr = (int'(wa) >= BASE_W) && (int'(wa) <= LAST_W);

  assert_err_src_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rerr_o |-> $past(req_i && !we_i && (int'(wa) > LAST_W)));

  assert_err_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rerr_o |-> (rdata_o == '0));

  assert_closed_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !region_open |=> ($stable(coarse_o) && $stable(fine_o)));

  assert_bad_sig_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && slot_addr && (wdata_i[17:12] != 6'h29))
      |=> ($stable(coarse_o) && $stable(fine_o)));

  assert_key_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(region_open) |-> $past(req_i && we_i && (addr_i[ADDR_W-1:2] == 10'd11)));

  assert_rd_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));
endmodule

bind iodly_cfg_bank iodly_cfg_bank_chk #(
  .NUM_SLOTS (NUM_SLOTS),
  .BASE_OFF  (BASE_OFF)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .rerr_o      (rerr_o),
  .coarse_o    (coarse_o),
  .fine_o      (fine_o),
  .region_open (region_open)
);

// File: tb/iodly_cfg_bank_tb.sv
`timescale 1ns/1ps
module iodly_cfg_bank_tb;
  localparam int NS = 828;
  localparam int CW = 5;

  logic            clk, rst_ni, req, we;
  logic [11:0]     addr;
  logic [31:0]     wdata;
  logic [15:0]     refclk, cref, cdly, fref, fdly;
  logic [31:0]     rdata;
  logic            rerr;
  logic [NS*CW-1:0] coarse, fine;

  iodly_cfg_bank u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .refclk_period_i(refclk), .crs_ref_i(cref),
    .crs_dly_i(cdly), .fin_ref_i(fref), .fin_dly_i(fdly),
    .rdata_o(rdata), .rerr_o(rerr), .coarse_o(coarse), .fine_o(fine)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit started = 0;

  // behavioural model
  bit          m_open;
  bit          m_lock [NS];
  int          m_crs  [NS];
  int          m_fin  [NS];
  logic [31:0] m_rdata;
  bit          m_err;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int slot_of(input logic [11:0] a);
    int w = int'(a[11:2]);
    if (w >= 12 && w < 12 + NS) return w - 12;
    return -1;
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    int k = slot_of(a);
    if (k >= 0) return (32'h29 << 12) | (32'(m_lock[k]) << 10) | (32'(m_crs[k]) << 5) | 32'(m_fin[k]);
    case (int'(a[11:2]))
      11: return m_open ? 32'h0000AAAA : 32'h0000AAAB;
      5:  return {16'h0, refclk};
      6:  return {cdly, cref};
      7:  return {fdly, fref};
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_apply(input bit w, input logic [11:0] a, input logic [31:0] d);
    int k;
    if (!w) begin
      m_err   = int'(a[11:2]) > 12 + NS - 1;
      m_rdata = m_err ? 32'h0 : m_read(a);
    end else begin
      m_err = 0;
      k = slot_of(a);
      if (int'(a[11:2]) == 11) begin
        if (d[15:0] == 16'hAAAA) m_open = 1;
        else if (d[15:0] == 16'hAAAB) m_open = 0;
      end else if (k >= 0 && m_open && d[17:12] == 6'h29 && (!m_lock[k] || !d[10])) begin
        m_lock[k] = d[10];
        m_crs[k]  = int'(d[9:5]);
        m_fin[k]  = int'(d[4:0]);
      end
    end
  endtask

  task automatic op(input bit w, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = w; addr = a; wdata = d;
    @(posedge clk);
    m_apply(w, a, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req = 0;
      @(posedge clk);
      m_err = 0;
    end
  endtask

  // read and compare against a value derived from the requirements
  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input bit exp_err, input string tag);
    op(0, a, 32'h0);
    @(negedge clk);
    req = 0;
    check(rdata === exp, tag, rdata, exp);
    check(rerr === exp_err, {tag, " err"}, 32'(rerr), 32'(exp_err));
    @(posedge clk);
    m_err = 0;
  endtask

  function automatic logic [31:0] slot_word(input bit lk, input int c, input int f, input logic [5:0] sig);
    return (32'(sig) << 12) | (32'(lk) << 10) | (32'(c) << 5) | 32'(f);
  endfunction

  // per-cycle comparison with the model
  always @(negedge clk) begin
    if (started) begin
      bit ok = 1;
      for (int i = 0; i < NS; i++)
        if (coarse[i*CW +: CW] !== CW'(m_crs[i]) || fine[i*CW +: CW] !== CW'(m_fin[i])) ok = 0;
      check(ok, "R6 outputs vs model", 32'(ok), 32'h1);
      check(rdata === m_rdata, "R11 rdata vs model", rdata, m_rdata);
      check(rerr === m_err, "R10 rerr vs model", 32'(rerr), 32'(m_err));
    end
  end

  initial begin
    #(200000 * 8);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    req = 0; we = 0; addr = '0; wdata = '0; rst_ni = 0;
    refclk = 16'h1234; cref = 16'h0BCD; cdly = 16'h00A5; fref = 16'h0FED; fdly = 16'h0033;
    m_open = 0; m_rdata = 0; m_err = 0;
    for (int i = 0; i < NS; i++) begin m_lock[i] = 1; m_crs[i] = 0; m_fin[i] = 0; end
    repeat (3) @(negedge clk);
    rst_ni = 1;
    started = 1;

    // R1 reset state
    check(coarse === '0 && fine === '0, "R1 outputs zero", 32'(|{coarse, fine}), 32'h0);
    rd_chk(12'h02C, 32'h0000AAAB, 0, "R1 key reads closed");
    rd_chk(12'h030, 32'h00029400, 0, "R1 slot0 locked");

    // R3 closed region ignores a valid write
    op(1, 12'h030, slot_word(0, 3, 7, 6'h29));
    rd_chk(12'h030, 32'h00029400, 0, "R3 closed write ignored");

    // R2 key handling
    op(1, 12'h02C, 32'h1234AAAA);
    rd_chk(12'h02C, 32'h0000AAAA, 0, "R2 open with upper bits set");
    op(1, 12'h02C, 32'h00005555);
    rd_chk(12'h02C, 32'h0000AAAA, 0, "R2 foreign key no change");

    // R4 bad signature
    op(1, 12'h044, slot_word(0, 17, 9, 6'h28));
    rd_chk(12'h044, 32'h00029400, 0, "R4 bad signature ignored");

    // R5 lock handling
    op(1, 12'h044, slot_word(1, 17, 9, 6'h29));
    rd_chk(12'h044, 32'h00029400, 0, "R5 locked keep lock ignored");
    op(1, 12'h044, slot_word(0, 17, 9, 6'h29));
    rd_chk(12'h044, 32'h00029229, 0, "R5 clearing write accepted");
    idle(1);
    check(coarse[5*CW +: CW] === 5'd17 && fine[5*CW +: CW] === 5'd9, "R6 slot5 outputs",
          32'({coarse[5*CW +: CW], fine[5*CW +: CW]}), 32'({5'd17, 5'd9}));
    op(1, 12'h046, slot_word(1, 31, 31, 6'h29));
    rd_chk(12'h044, 32'h000297FF, 0, "R5 unlocked slot takes lock R7 low bits");
    op(1, 12'h044, slot_word(1, 2, 2, 6'h29));
    rd_chk(12'h044, 32'h000297FF, 0, "R5 relock ignored");
    op(1, 12'h044, slot_word(0, 1, 30, 6'h29));
    rd_chk(12'h044, 32'h0002903E, 0, "R5 clear again");
    rd_chk(12'h040, 32'h00029400, 0, "R7 neighbour untouched");

    // R7 last slot and edges; R8 format
    op(1, 12'hD1C, slot_word(0, 21, 11, 6'h29));
    rd_chk(12'hD1C, 32'h000292AB, 0, "R8 last slot readback");
    idle(1);
    check(coarse[(NS-1)*CW +: CW] === 5'd21, "R7 last slot output", 32'(coarse[(NS-1)*CW +: CW]), 32'd21);
    op(1, 12'hD20, slot_word(0, 9, 9, 6'h29));
    rd_chk(12'hD20, 32'h0, 1, "R10 read past top");
    rd_chk(12'hFFC, 32'h0, 1, "R10 read at 0xFFC");
    rd_chk(12'h000, 32'h0, 0, "R10 unmapped in range");
    rd_chk(12'h028, 32'h0, 0, "R10 unmapped 0x28");
    op(0, 12'hD20, 0);
    op(0, 12'hE00, 0);
    idle(2);

    // R9 calibration reads and write immunity
    rd_chk(12'h014, 32'h00001234, 0, "R9 refclk");
    op(1, 12'h018, 32'hFFFFFFFF);
    rd_chk(12'h018, 32'h00A50BCD, 0, "R9 coarse cal after write");
    rd_chk(12'h01C, 32'h00330FED, 0, "R9 fine cal");

    // R11 hold across idle cycles
    idle(4);
    check(rdata === 32'h00330FED, "R11 hold", rdata, 32'h00330FED);

    // random traffic checked against the model
    void'($urandom(32'd7));
    for (int n = 0; n < 300; n++) begin
      logic [31:0] r = $urandom;
      logic [11:0] a = 12'(12'h030 + 4 * ($urandom % NS));
      logic [31:0] d = {14'h0, (r[31:30] == 0) ? 6'(r[29:24]) : 6'h29, 1'b0, r[10:0] & 11'h7FF};
      if (n == 150) op(1, 12'h02C, 32'h0000AAAB);
      if (n == 200) op(1, 12'h02C, 32'h0000AAAA);
      op(r[20], a, d);
    end
    idle(1);

    // R3 after closing: no write reaches slots
    op(1, 12'h02C, 32'h0000AAAB);
    rd_chk(12'h02C, 32'h0000AAAB, 0, "R2 closed again");
    op(1, 12'h034, slot_word(0, 4, 4, 6'h29));
    idle(1);
    rd_chk(12'h034, m_read(12'h034), 0, "R3 closed after traffic");

    idle(2);
    started = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule